// File: doc/BRIEF.md
# Seconds Timer with Alarm

This peripheral keeps a free-running count of whole seconds. A programmable divider turns the slow input clock into a one-per-second tick, and a 32-bit up-counter advances once per tick. Software can never load the counter with a value of its own. The only way to change it is to return it to zero, and that happens through a self-clearing restart bit in the mode register. A 32-bit alarm register is compared with the counter on every tick.

Two sticky status flags record events: one for the alarm matching and one for each counter step. Reading the status register clears both flags. Each flag has its own interrupt enable bit in the mode register. Each enable sits 16 bit positions above its status flag, so shifting the enable field right by 16 lines it up with the status field. The single interrupt line is high while any enabled flag is set.

The register port is a simple synchronous bus with a write strobe and a read strobe. Read data appears one clock after the read strobe. Every pin is a plain control or status signal, so there is no streaming handshake and no back-pressure.

Top module: `sectmr_top`

Register map (word select `bus_addr`):
- 0, mode: bits [15:0] hold the divider value, bit 16 is the alarm interrupt enable, bit 17 is the step interrupt enable, and bit 18 is the restart bit (write-only, always reads 0).
- 1, alarm: the alarm value. It resets to 0xFFFFFFFF.
- 2, count: the counter value. This register is read-only.
- 3, status: bit 0 is the alarm flag and bit 1 is the step flag. A read clears both flags, and writes are ignored.

## Requirements
- R1: After a restart, the counter reaches value k exactly k*D clock cycles after the restart edge, where D is the effective divider. It changes by at most +1 per cycle.
- R2: A divider field of 0 gives D = 65536, a field of 1 gives D = 2, and any other value N gives D = N.
- R3: Writes to the count address (2) have no effect, and the counter keeps its value.
- R4: A mode write with bit 18 set makes the counter read 0 and restarts the divider phase. Bit 18 reads back as 0, while bits [17:0] read back exactly as written.
- R5: The alarm register resets to 0xFFFFFFFF and reads back whatever was last written to it.
- R6: Status bit 0 sets on the clock edge where the counter steps to a value equal to the alarm register. It never sets while the alarm register holds 0xFFFFFFFF.
- R7: Status bit 1 sets on every counter step that is not cancelled by a restart.
- R8: A status read returns the flags as they stood before the read, then clears them. An event arriving on the same edge as the read is kept and returned by the next read.
- R9: `irq` is high exactly when (status bit 0 AND mode bit 16) OR (status bit 1 AND mode bit 17).
- R10: After reset, the divider field equals DEF_PRESC, both enables are 0, the count is 0, the status is 0 and `irq` is 0. Read data is valid one clock after the read strobe.
- R11: Writes to the status address (3) do not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock: clocks the divider, the counter and the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered one clock after `bus_rd` |
| irq | output | 1 | Interrupt line, high while an enabled flag is set |

## Verification
The bench measures the tick period to the exact cycle for the dividers 4, 1 and 0. A design that miscounts its wrap point, or that takes 0 or 1 literally, reads back a step one cycle early or late, or never steps at all.

The bench also issues a status read on the same edge where the alarm matches. A design that lets the clear win over the new event loses that alarm for good.

Finally, the bench checks the interrupt gating with only one enable set at a time. It also writes to the count and status addresses and confirms both writes are ignored. A design with a crossed enable mapping, or with a counter that can be loaded, fails these checks at the ports.

// File: rtl/sectmr_pkg.sv
package sectmr_pkg;
  localparam int REG_ADDR_W  = 2;
  localparam int NUM_EVT     = 2;
  localparam int ST_ALARM    = 0;
  localparam int ST_INC      = 1;
  localparam int EN_SHIFT    = 16;
  localparam int RESTART_BIT = 18;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_ALARM  = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sectmr_prescaler.sv
module sectmr_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  localparam int DIV_W = PRE_W + 1;

  logic [DIV_W-1:0] div_last;
  logic [DIV_W-1:0] phase;

  // effective divider: 0 selects the largest count, 1 is promoted to 2
  always_comb begin
    if (presc == '0)
      div_last = {1'b0, {PRE_W{1'b1}}};
    else if (presc == PRE_W'(1))
      div_last = DIV_W'(1);
    else
      div_last = {1'b0, presc} - DIV_W'(1);
  end

  // >= keeps the phase bounded if the divider shrinks mid-period
  assign tick = (phase >= div_last);

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (restart || tick)
      phase <= '0;
    else
      phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/sectmr_counter.sv
module sectmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count,
  output logic             evt_step,
  output logic             evt_match
);
  logic [CNT_W-1:0] count_next;
  logic             alarm_off;

  assign count_next = count + CNT_W'(1);
  assign alarm_off  = (alarm == {CNT_W{1'b1}});
  assign evt_step   = tick && !restart;
  assign evt_match  = evt_step && !alarm_off && (count_next == alarm);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (restart)
      count <= '0;
    else if (tick)
      count <= count_next;
  end
endmodule

// File: rtl/sectmr_status.sv
module sectmr_status #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               clr,
  input  logic [NUM_EVT-1:0] en,
  output logic [NUM_EVT-1:0] sts,
  output logic               irq
);
  logic [NUM_EVT-1:0] gated;

  // a new event on the clearing edge survives the clear
  always_ff @(posedge clk) begin
    if (!rst_n)
      sts <= '0;
    else
      sts <= (clr ? '0 : sts) | evt;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_gate
    assign gated[i] = sts[i] & en[i];
  end

  assign irq = |gated;
endmodule

// File: rtl/sectmr_top.sv
module sectmr_top
  import sectmr_pkg::*;
#(
  parameter int          CNT_W     = 32,
  parameter int          PRE_W     = 16,
  parameter logic [15:0] DEF_PRESC = 16'h8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [CNT_W-1:0]      bus_wdata,
  input  logic                  bus_rd,
  output logic [CNT_W-1:0]      bus_rdata,
  output logic                  irq
);
  logic [PRE_W-1:0]   presc_q;
  logic [NUM_EVT-1:0] en_q;
  logic [CNT_W-1:0]   alarm_q;
  logic [CNT_W-1:0]   count_q;
  logic [NUM_EVT-1:0] sts_q;
  logic [NUM_EVT-1:0] evt;
  logic               tick;
  logic               restart;
  logic               sts_clr;
  logic               evt_step;
  logic               evt_match;
  logic [CNT_W-1:0]   mode_view;
  logic [CNT_W-1:0]   rd_mux;

  assign restart = bus_wr && (bus_addr == REG_MODE) && bus_wdata[RESTART_BIT];
  assign sts_clr = bus_rd && (bus_addr == REG_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= PRE_W'(DEF_PRESC);
      en_q    <= '0;
      alarm_q <= {CNT_W{1'b1}};
    end else if (bus_wr) begin
      case (bus_addr)
        REG_MODE: begin
          presc_q <= bus_wdata[PRE_W-1:0];
          en_q    <= bus_wdata[EN_SHIFT +: NUM_EVT];
        end
        REG_ALARM: alarm_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  sectmr_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .presc   (presc_q),
    .tick    (tick)
  );

  sectmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .restart   (restart),
    .alarm     (alarm_q),
    .count     (count_q),
    .evt_step  (evt_step),
    .evt_match (evt_match)
  );

  always_comb begin
    evt           = '0;
    evt[ST_ALARM] = evt_match;
    evt[ST_INC]   = evt_step;
  end

  sectmr_status #(.NUM_EVT(NUM_EVT)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .clr   (sts_clr),
    .en    (en_q),
    .sts   (sts_q),
    .irq   (irq)
  );

  always_comb begin
    mode_view                         = '0;
    mode_view[PRE_W-1:0]              = presc_q;
    mode_view[EN_SHIFT +: NUM_EVT]    = en_q;
    case (bus_addr)
      REG_MODE:  rd_mux = mode_view;
      REG_ALARM: rd_mux = alarm_q;
      REG_COUNT: rd_mux = count_q;
      default:   rd_mux = {{(CNT_W-NUM_EVT){1'b0}}, sts_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sectmr_checker.sv
module sectmr_checker #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  restart,
  input logic                  bus_rd,
  input logic [1:0]            bus_addr,
  input logic                  tick,
  input logic [CNT_W-1:0]      count,
  input logic [CNT_W-1:0]      alarm,
  input logic [1:0]            sts,
  input logic                  irq
);
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));

  assert_step_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> sts[1]);

  assert_alarm_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((alarm == {CNT_W{1'b1}}) && !sts[0]) |=> !sts[0]);

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 2'd3) && !tick) |=> (sts == 2'b00));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != 2'b00));
endmodule

bind sectmr_top sectmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .restart  (restart),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .tick     (tick),
  .count    (count_q),
  .alarm    (alarm_q),
  .sts      (sts_q),
  .irq      (irq)
);

// File: tb/tb_sectmr_top.sv
module tb_sectmr_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {do_write, waddr, wdata, raddr, expected}
  localparam logic [68:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 32'h0004_0000, 2'd0, 32'h0000_0000}, // R4 restart bit reads 0
    {1'b1, 2'd2, 32'hDEAD_BEEF, 2'd2, 32'h0000_0000}, // R3 count not writable
    {1'b1, 2'd1, 32'h1234_5678, 2'd1, 32'h1234_5678}, // R5 alarm readback
    {1'b1, 2'd0, 32'h0003_0000, 2'd0, 32'h0003_0000}, // R4 fields kept
    {1'b1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000}, // R4 fields kept
    {1'b1, 2'd3, 32'h0000_0003, 2'd3, 32'h0000_0000}  // R11 status write ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  logic [31:0] rv;

  sectmr_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    rd(2'd0, rv); chk("R10 mode reset", rv, 32'h0000_8000);
    rd(2'd1, rv); chk("R5 alarm reset", rv, 32'hFFFF_FFFF);
    rd(2'd2, rv); chk("R10 count reset", rv, 32'h0);
    rd(2'd3, rv); chk("R10 status reset", rv, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:66], VEC[i][65:34]);
      rd(VEC[i][33:32], rv);
      chk("R3/R4/R5/R11 vector", rv, VEC[i][31:0]);
    end

    // R1 exact period with divider 4 (restart edge E0)
    wr(2'd0, 32'h0004_0004);
    idle(3);
    rd(2'd2, rv); chk("R1 count before first step", rv, 32'd0);
    rd(2'd2, rv); chk("R1 count after first step", rv, 32'd1);
    rd(2'd3, rv); chk("R7 step flag", rv, 32'h2);

    // R2 divider 1 acts as 2
    wr(2'd0, 32'h0004_0001);
    idle(1);
    rd(2'd2, rv); chk("R2 div1 before step", rv, 32'd0);
    rd(2'd2, rv); chk("R2 div1 step at 2", rv, 32'd1);

    // R2 divider 0 acts as 65536
    wr(2'd0, 32'h0004_0000);
    idle(65535);
    rd(2'd2, rv); chk("R2 div0 before step", rv, 32'd0);
    rd(2'd2, rv); chk("R2 div0 step at 65536", rv, 32'd1);

    // R6/R8 alarm at 3 with divider 4, read collides with match edge
    wr(2'd1, 32'd3);
    rd(2'd3, rv);
    wr(2'd0, 32'h0004_0004);
    idle(10);
    rd(2'd3, rv); chk("R8 status before match", rv, 32'h2);
    rd(2'd3, rv); chk("R8 read on match edge", rv, 32'h0);
    rd(2'd3, rv); chk("R6 alarm kept for next read", rv, 32'h3);
    rd(2'd2, rv); chk("R6 count equals alarm", rv, 32'd3);

    // R9 step enable only
    rd(2'd3, rv);
    wr(2'd0, 32'h0006_0004);
    chk("R9 irq idle", {31'b0, irq}, 32'h0);
    idle(4);
    chk("R9 irq on step", {31'b0, irq}, 32'h1);
    rd(2'd3, rv); chk("R8 status read", rv, 32'h2);
    chk("R9 irq cleared by read", {31'b0, irq}, 32'h0);

    // R9 alarm enable only: step flag gated off
    wr(2'd0, 32'h0005_0004);
    idle(4);
    chk("R9 step not enabled", {31'b0, irq}, 32'h0);
    idle(8);
    chk("R9 irq on alarm", {31'b0, irq}, 32'h1);

    // R6 all-ones alarm never flags
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0004_0002);
    rd(2'd3, rv);
    idle(20);
    rd(2'd3, rv); chk("R6 disabled alarm", rv, 32'h2);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule